// File: doc/BRIEF.md
# Microprogram Sequencer with Condition Select

This block steps through a 64-word microprogram and hands a 16-bit datapath control word to the processor datapath, one microinstruction at a time. A 6-bit control address register (CAR) addresses an internal microprogram store of 26-bit words. The word is read synchronously into a control data register (CDR). That register drives the control word and also holds the sequencing fields for the current microinstruction. The datapath is outside the block. Its carry, zero, sign and overflow flags arrive as inputs.

Each microinstruction runs through two named states of a small state machine. In FETCH, the word at CAR is captured into the CDR. In STEP, the control word is valid and `step_en` is high. A status multiplexer picks one condition with the 3-bit select field. If the condition is true, CAR is loaded, either from the next-address field or from the external address input, as the address-source bit chooses. If the condition is false, CAR increments and wraps from 63 to 0. The transitions are: reset enters FETCH; FETCH always goes to STEP; STEP always returns to FETCH. The store is written through a load port, normally while reset is held.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low and after its release, before the first edge, `car` is 0, `ctrl_word` is 0 (transfer A, destination none, no shift) and `step_en` is 0.
- R2: After reset the state machine alternates FETCH and STEP on every clock, starting with FETCH; `step_en` is high exactly in STEP.
- R3: The clock edge that leaves FETCH loads the CDR with the store word at the current `car`; `ctrl_word` shows bits [15:0] of that word and holds them through STEP.
- R4: The condition select field is bits [19:17] of the word. Its codes are: 0 false, 1 true, 2 `flag_c`, 3 not `flag_c`, 4 `flag_z`, 5 not `flag_z`, 6 `flag_s`, 7 `flag_v`. The flags are sampled during STEP.
- R5: At the end of STEP, when the condition is true and bit 16 (address source) is 0, `car` takes bits [25:20] of the word.
- R6: At the end of STEP, when the condition is true and bit 16 is 1, `car` takes `ext_addr`.
- R7: At the end of STEP, when the condition is false, `car` becomes `car`+1 modulo 64, so 63 is followed by 0.
- R8: During FETCH, the flags and `ext_addr` have no effect: `car` does not change across the FETCH edge.
- R9: When `ld_en` is high at a clock edge, `ld_data` is written to store address `ld_addr`. This also happens while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_c | input | 1 | Datapath carry flag |
| flag_z | input | 1 | Datapath zero flag |
| flag_s | input | 1 | Datapath sign flag |
| flag_v | input | 1 | Datapath overflow flag |
| ext_addr | input | 6 | External branch address |
| ld_en | input | 1 | Store write enable |
| ld_addr | input | 6 | Store write address |
| ld_data | input | 26 | Store write data (microinstruction) |
| ctrl_word | output | 16 | Datapath control word from the CDR |
| step_en | output | 1 | High while the control word is being executed |
| car | output | 6 | Control address register |

## Verification
Three programs are loaded, and each one isolates a different part of the next-address choice. The first program mixes all eight condition codes and both address sources, and the flags and external address are random. It shows whether each select code picks the right flag and polarity, and whether field and external loads are kept apart. The second program uses only the "false" code, so it walks the whole store by incrementing and exposes any fault in the 63-to-0 wrap or in the read address. The third program uses "true" with the external source, so every jump follows `ext_addr`; because `ext_addr` also changes during FETCH, it shows whether that input is kept out of the FETCH edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned UQ_AW    = 6;
    localparam int unsigned UQ_CW_W  = 16;
    localparam int unsigned UQ_SEL_W = 3;
    localparam int unsigned UQ_UI_W  = UQ_CW_W + 1 + UQ_SEL_W + UQ_AW;
    localparam int unsigned UQ_DEPTH = 1 << UQ_AW;

    // Status-select codes; order is behaviour (R4)
    typedef enum logic [UQ_SEL_W-1:0] {
        CS_FALSE = 3'd0,
        CS_TRUE  = 3'd1,
        CS_C     = 3'd2,
        CS_NC    = 3'd3,
        CS_Z     = 3'd4,
        CS_NZ    = 3'd5,
        CS_S     = 3'd6,
        CS_V     = 3'd7
    } cond_sel_e;

    typedef enum logic {
        SRC_FIELD = 1'b0,
        SRC_EXT   = 1'b1
    } addr_src_e;

    // Microinstruction: [25:20] next, [19:17] select, [16] source, [15:0] control
    typedef struct packed {
        logic [UQ_AW-1:0]   nxt;
        cond_sel_e          sel;
        addr_src_e          src;
        logic [UQ_CW_W-1:0] cw;
    } uinstr_t;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_STEP  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read register doubles as the control data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  cond_sel_e sel,
    input  flags_t    flags,
    output logic      cond
);

    always_comb begin
        unique case (sel)
            CS_FALSE: cond = 1'b0;
            CS_TRUE:  cond = 1'b1;
            CS_C:     cond = flags.c;
            CS_NC:    cond = ~flags.c;
            CS_Z:     cond = flags.z;
            CS_NZ:    cond = ~flags.z;
            CS_S:     cond = flags.s;
            CS_V:     cond = flags.v;
            default:  cond = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic [AW-1:0] cur,
    input  logic          cond,
    input  addr_src_e     src,
    input  logic [AW-1:0] field_addr,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] load_addr;
    logic [AW-1:0] inc_addr;

    assign inc_addr  = cur + AW'(1);
    assign load_addr = (src == SRC_EXT) ? ext_addr : field_addr;
    assign nxt       = cond ? load_addr : inc_addr;

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int unsigned AW   = UQ_AW,
    parameter int unsigned CW_W = UQ_CW_W,
    parameter int unsigned UI_W = UQ_UI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flag_c,
    input  logic            flag_z,
    input  logic            flag_s,
    input  logic            flag_v,
    input  logic [AW-1:0]   ext_addr,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_addr,
    input  logic [UI_W-1:0] ld_data,
    output logic [CW_W-1:0] ctrl_word,
    output logic            step_en,
    output logic [AW-1:0]   car
);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic          rd_en;
    logic [UI_W-1:0] cdr_raw;
    uinstr_t       ui;
    flags_t        flags;
    logic          cond;
    logic [AW-1:0] car_nxt;

    assign flags = '{c: flag_c, z: flag_z, s: flag_s, v: flag_v};

    useq_store #(
        .AW (AW),
        .DW (UI_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_en   (rd_en),
        .rd_addr (car),
        .rd_q    (cdr_raw)
    );

    assign ui = uinstr_t'(cdr_raw);

    useq_cond_mux u_cond (
        .sel   (ui.sel),
        .flags (flags),
        .cond  (cond)
    );

    useq_next_addr #(
        .AW (AW)
    ) u_next (
        .cur        (car),
        .cond       (cond),
        .src        (ui.src),
        .field_addr (ui.nxt),
        .ext_addr   (ext_addr),
        .nxt        (car_nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and state-decoded outputs
    always_comb begin
        state_d = state_q;
        rd_en   = 1'b0;
        step_en = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                rd_en   = 1'b1;
                state_d = ST_STEP;
            end
            ST_STEP: begin
                step_en = 1'b1;
                state_d = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    // Control address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car <= '0;
        end else if (state_q == ST_STEP) begin
            car <= car_nxt;
        end
    end

    assign ctrl_word = ui.cw;

    AST_STEP_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> !step_en); // R2
    AST_STEP_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> step_en); // R2
    AST_CW_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> $stable(ctrl_word)); // R3
    AST_CAR_HOLD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> (car == $past(car))); // R8
    AST_LOAD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cond && ui.src == SRC_FIELD) |=> (car == $past(ui.nxt))); // R5
    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cond && ui.src == SRC_EXT) |=> (car == $past(ext_addr))); // R6
    AST_INCR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !cond) |=> (car == AW'($past(car) + AW'(1)))); // R7

endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_c = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_v = 1'b0;
    logic [5:0]  ext_addr = '0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [25:0] ld_data = '0;
    logic [15:0] ctrl_word;
    logic        step_en;
    logic [5:0]  car;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [25:0] m_mem [64];
    int          m_car;
    logic [25:0] m_cdr;
    bit          m_step;
    string       car_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v),
        .ext_addr(ext_addr), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .ctrl_word(ctrl_word), .step_en(step_en), .car(car)
    );

    function automatic logic [25:0] prog_word(int mode, int a);
        logic [5:0]  nx;
        logic [2:0]  sel;
        logic        src;
        logic [15:0] cw;
        cw  = 16'((a * 40503) ^ 16'h5A3C ^ (mode << 12));
        nx  = 6'((a * 11 + 5) % 64);
        if (mode == 0) begin
            sel = (a == 63) ? 3'd0 : 3'(a % 8);
            src = 1'(a >> 1);
        end else if (mode == 1) begin
            sel = 3'd0;
            src = 1'(a);
        end else begin
            sel = 3'd1;
            src = 1'b1;
        end
        return {nx, sel, src, cw};
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_cond(logic [2:0] sel);
        case (sel) // R4 codes
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return flag_c;
            3'd3: return !flag_c;
            3'd4: return flag_z;
            3'd5: return !flag_z;
            3'd6: return flag_s;
            default: return flag_v;
        endcase
    endfunction

    task automatic load_prog(int mode);
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < 64; a++) begin
            ld_en   = 1'b1;
            ld_addr = 6'(a);
            ld_data = prog_word(mode, a);
            m_mem[a] = ld_data;
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        // reset values held under reset (R1)
        check("R1", car, 0, "car in reset");
        check("R1", ctrl_word, 0, "ctrl_word in reset");
        check("R1", step_en, 0, "step_en in reset");
        rst_n  = 1'b1;
        m_car  = 0;
        m_cdr  = '0;
        m_step = 0;
        car_tag = "R1";
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) begin
            check(car_tag, car, m_car, "car");
            check("R3 R9", ctrl_word, m_cdr[15:0], "ctrl_word");
            check("R2", step_en, m_step, "step_en");
            {flag_c, flag_z, flag_s, flag_v} = 4'($urandom);
            ext_addr = 6'($urandom);
            if (!m_step) begin
                m_cdr   = m_mem[m_car];
                m_step  = 1;
                car_tag = "R8";
            end else begin
                if (model_cond(m_cdr[19:17])) begin
                    if (m_cdr[16]) begin
                        m_car = ext_addr;
                        car_tag = "R6 R4";
                    end else begin
                        m_car = m_cdr[25:20];
                        car_tag = "R5 R4";
                    end
                end else begin
                    m_car = (m_car + 1) % 64;
                    car_tag = "R7 R4";
                end
                m_step = 0;
            end
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        load_prog(0);   // mixed conditions and sources
        run(3000);
        load_prog(1);   // increment only: full walk and wrap (R7)
        run(300);
        load_prog(2);   // always jump to external address (R6, R8)
        run(600);
        done = 1;
        summary();
        $finish;
    end

endmodule